// File: doc/BRIEF.md
# Address Window Decoder with Translation

This block holds six address windows ("images"), each defined on address bits 31..12 by a base, a mask and a translation address, plus per-image control bits. A 32-bit lookup address and an access type (memory or I/O) are compared against every implemented image. The lowest-numbered image that matches wins. The block then produces a registered result one clock later: a one-hot hit vector, an any-hit flag, the winning index, the outbound address and the prefetch permission of that image.

Image 0 can be fixed as a configuration window. Image 1 is always present. Images 2..5 exist only up to the parameter `NUM_GEN`. Software programs the windows through a simple select/field write port and reads them back through a combinational read port.

Top module: `addr_window_xlat`

## Requirements
- R1: Field codes on `cfg_fld` are 0=base, 1=mask, 2=translation, 3=control. Base reads {bits 31..12, zeros, bit 0 = I/O space}, mask and translation read {bits 31..12, twelve zeros}, and control reads bit 2 = translate enable and bit 1 = prefetch. After reset, a general image reads base 0, mask 0xFFF00000 (1 MiB), translation 0 and control 0.
- R2: A written mask is normalised to contiguous ones from bit 31: every bit below the first zero is cleared.
- R3: An image matches when its mask is nonzero, its base bit 0 equals `lk_io`, and the address bits 31..12 equal the base bits wherever the mask is 1.
- R4: When several images match, only the lowest-numbered one is reported. `res_hit_vec` is one-hot (bit i = image i), `res_idx` is its number and `res_hit` is set. On a miss the vector is zero, `res_hit` is 0 and `res_idx` is 0.
- R5: With translate enable set, outbound bits 31..12 take the translation bits where the mask is 1 and the lookup bits where it is 0. With it clear, or on a miss, the lookup address passes through. Bits 11..0 always pass through.
- R6: With `CFG_IMG0`=1, image 0 keeps mask 0xFFFFF000, reads translation and control as 0, forces base bit 0 to 0, ignores mask, translation and control writes, and never matches an I/O access.
- R7: Images above `NUM_GEN` (and select codes 6 and 7) read as zero in every field, ignore writes and never match.
- R8: Results appear one clock after the lookup cycle. If `lk_valid` was low in that cycle, `res_valid`, `res_hit`, `res_hit_vec` and `res_prefetch` are 0.
- R9: `res_prefetch` equals the prefetch control bit of the winning image, and is 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the selected field |
| cfg_img | input | 3 | Image select (0..5) |
| cfg_fld | input | 2 | Field select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected field (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_io | input | 1 | Access type: 1 = I/O, 0 = memory |
| res_valid | output | 1 | Registered lookup valid |
| res_hit | output | 1 | Any image matched |
| res_hit_vec | output | 6 | One-hot winning image |
| res_idx | output | 3 | Winning image number |
| res_addr | output | 32 | Outbound address |
| res_prefetch | output | 1 | Prefetch permission of the winner |

## Verification
The bench makes overlapping windows match the same address and checks that the lower number wins. A reversed priority chain would report the higher image or a vector with two bits set. It writes broken masks to check normalisation, since a mask stored as written gives holes that decode aliased addresses. It also checks that a zero mask disables an image rather than matching everything. Translation is checked bit by bit against the mask, including the low twelve bits, which a wrong merge would corrupt. The fixed configuration image is hit with I/O accesses and writes to its locked fields, and absent images are written and then looked up, so that any leftover storage shows up as a readback or a hit.

// File: rtl/awx_pkg.sv
package awx_pkg;
  localparam int AWX_MAX_IMG = 6;
  localparam int AWX_IDXW    = 3;
  localparam int AWX_PW      = 20;   // page bits 31..12

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_XLAT = 2'd2,
    FLD_CTRL = 2'd3
  } awx_fld_e;

  // keep ones from the top down to the first zero, clear the rest
  function automatic logic [AWX_PW-1:0] awx_norm_mask(input logic [AWX_PW-1:0] m);
    logic keep;
    logic [AWX_PW-1:0] r;
    keep = 1'b1;
    for (int b = AWX_PW-1; b >= 0; b--) begin
      keep = keep & m[b];
      r[b] = keep;
    end
    return r;
  endfunction

  function automatic logic awx_match(input logic [AWX_PW-1:0] base,
                                     input logic [AWX_PW-1:0] mask,
                                     input logic base_io,
                                     input logic [AWX_PW-1:0] page,
                                     input logic acc_io);
    return (mask != '0) && (base_io == acc_io) && (((page ^ base) & mask) == '0);
  endfunction

  function automatic logic [AWX_PW-1:0] awx_translate(input logic [AWX_PW-1:0] page,
                                                      input logic [AWX_PW-1:0] xlat,
                                                      input logic [AWX_PW-1:0] mask,
                                                      input logic en);
    return en ? ((xlat & mask) | (page & ~mask)) : page;
  endfunction
endpackage

// File: rtl/awx_image.sv
module awx_image
  import awx_pkg::*;
#(
  parameter bit              IMPL     = 1'b1,
  parameter bit              CFG      = 1'b0,
  parameter logic [AWX_PW-1:0] DEF_MASK = 20'hFFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        fld,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [AWX_PW-1:0] page,
  input  logic              acc_io,
  output logic              hit,
  output logic [AWX_PW-1:0] xpage,
  output logic              pf
);
  logic [AWX_PW-1:0] base_q, mask_q, xlat_q;
  logic              io_q, xen_q, pf_q;

  generate
    if (!IMPL) begin : g_absent
      assign base_q = '0;
      assign mask_q = '0;
      assign xlat_q = '0;
      assign io_q   = 1'b0;
      assign xen_q  = 1'b0;
      assign pf_q   = 1'b0;
      logic unused_absent;
      assign unused_absent = ^{clk, rst_n, we, wdata};
    end else if (CFG) begin : g_cfg
      always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else if (we && fld == FLD_BASE) base_q <= wdata[31:12];
      end
      assign mask_q = '1;
      assign xlat_q = '0;
      assign io_q   = 1'b0;
      assign xen_q  = 1'b0;
      assign pf_q   = 1'b0;
      logic unused_cfg;
      assign unused_cfg = ^wdata[11:0];
      assert_cfg_no_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_io |-> !hit);
    end else begin : g_gen
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          base_q <= '0;
          mask_q <= DEF_MASK;
          xlat_q <= '0;
          io_q   <= 1'b0;
          xen_q  <= 1'b0;
          pf_q   <= 1'b0;
        end else if (we) begin
          case (fld)
            FLD_BASE: begin base_q <= wdata[31:12]; io_q <= wdata[0]; end
            FLD_MASK: mask_q <= awx_norm_mask(wdata[31:12]);
            FLD_XLAT: xlat_q <= wdata[31:12];
            default:  begin xen_q <= wdata[2]; pf_q <= wdata[1]; end
          endcase
        end
      end
      logic unused_gen;
      assign unused_gen = ^wdata[11:3];
      assert_mask_contig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mask_q + 20'd1));
    end
  endgenerate

  always_comb begin
    case (fld)
      FLD_BASE: rdata = {base_q, 11'b0, io_q};
      FLD_MASK: rdata = {mask_q, 12'b0};
      FLD_XLAT: rdata = {xlat_q, 12'b0};
      default:  rdata = {29'b0, xen_q, pf_q, 1'b0};
    endcase
  end

  assign hit   = awx_match(base_q, mask_q, io_q, page, acc_io);
  assign xpage = awx_translate(page, xlat_q, mask_q, xen_q);
  assign pf    = pf_q;
endmodule

// File: rtl/awx_prio.sv
module awx_prio
  import awx_pkg::*;
#(
  parameter int N = AWX_MAX_IMG
) (
  input  logic [N-1:0]        hits,
  output logic [N-1:0]        win,
  output logic [AWX_IDXW-1:0] idx
);
  always_comb begin
    win = '0;
    idx = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (hits[i]) begin
        win = '0;
        win[i] = 1'b1;
        idx = AWX_IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
  import awx_pkg::*;
#(
  parameter int                NUM_GEN  = 5,
  parameter bit                CFG_IMG0 = 1'b1,
  parameter logic [AWX_PW-1:0] DEF_MASK = 20'hFFF00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_img,
  input  logic [1:0]  cfg_fld,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  input  logic        lk_io,
  output logic        res_valid,
  output logic        res_hit,
  output logic [5:0]  res_hit_vec,
  output logic [2:0]  res_idx,
  output logic [31:0] res_addr,
  output logic        res_prefetch
);
  localparam int NIMG = AWX_MAX_IMG;

  logic [31:0]       rd_arr [NIMG];
  logic [AWX_PW-1:0] xp_arr [NIMG];
  logic [NIMG-1:0]   hits, pfs, win;
  logic [AWX_IDXW-1:0] win_idx;

  for (genvar i = 0; i < NIMG; i++) begin : g_img
    localparam bit IMPL = (i == 0) || (i <= NUM_GEN);
    logic we_i;
    assign we_i = cfg_we && (cfg_img == AWX_IDXW'(i));
    awx_image #(.IMPL(IMPL), .CFG((i == 0) && CFG_IMG0), .DEF_MASK(DEF_MASK)) u_img (
      .clk(clk), .rst_n(rst_n), .we(we_i), .fld(cfg_fld), .wdata(cfg_wdata),
      .rdata(rd_arr[i]), .page(lk_addr[31:12]), .acc_io(lk_io),
      .hit(hits[i]), .xpage(xp_arr[i]), .pf(pfs[i]));
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NIMG; i++)
      if (cfg_img == AWX_IDXW'(i)) cfg_rdata = rd_arr[i];
  end

  awx_prio #(.N(NIMG)) u_prio (.hits(hits), .win(win), .idx(win_idx));

  logic [AWX_PW-1:0] win_page;
  logic              win_pf;
  always_comb begin
    win_page = lk_addr[31:12];
    win_pf   = 1'b0;
    for (int i = 0; i < NIMG; i++)
      if (win[i]) begin win_page = xp_arr[i]; win_pf = pfs[i]; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_hit      <= 1'b0;
      res_hit_vec  <= '0;
      res_idx      <= '0;
      res_addr     <= '0;
      res_prefetch <= 1'b0;
    end else begin
      res_valid    <= lk_valid;
      res_hit      <= lk_valid && (hits != '0);
      res_hit_vec  <= lk_valid ? win : '0;
      res_idx      <= lk_valid ? win_idx : '0;
      res_addr     <= {win_page, lk_addr[11:0]};
      res_prefetch <= lk_valid && win_pf;
    end
  end

  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_hit_vec));
  assert_flag_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit == (res_hit_vec != '0));
  assert_low_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_addr[11:0] == $past(lk_addr[11:0]));
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && !res_prefetch));
endmodule

// File: tb/addr_window_xlat_test.sv
module addr_window_xlat_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_img = '0;
  logic [1:0]  cfg_fld = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_io = 1'b0;
  logic        res_valid, res_hit, res_prefetch;
  logic [5:0]  res_hit_vec;
  logic [2:0]  res_idx;
  logic [31:0] res_addr;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  addr_window_xlat #(.NUM_GEN(3), .CFG_IMG0(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_img(cfg_img), .cfg_fld(cfg_fld),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_io(lk_io), .res_valid(res_valid), .res_hit(res_hit), .res_hit_vec(res_hit_vec),
    .res_idx(res_idx), .res_addr(res_addr), .res_prefetch(res_prefetch));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int img, input int fld, input logic [31:0] d);
    @(negedge clk);
    cfg_img = 3'(img); cfg_fld = 2'(fld); cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int img, input int fld, input logic [31:0] exp);
    @(negedge clk);
    cfg_img = 3'(img); cfg_fld = 2'(fld);
    #1 chk(req, cfg_rdata, exp);
  endtask

  // drive one lookup, sample the registered result after one edge
  task automatic look(input string req, input logic [31:0] a, input logic io, input logic v,
                      input logic [5:0] evec, input logic [2:0] eidx,
                      input logic [31:0] eaddr, input logic epf);
    @(negedge clk);
    lk_addr = a; lk_io = io; lk_valid = v;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " valid"}, {31'b0, res_valid}, {31'b0, v});
    chk({req, " hit"}, {31'b0, res_hit}, {31'b0, evec != 6'b0});
    chk({req, " vec"}, {26'b0, res_hit_vec}, {26'b0, evec});
    chk({req, " idx"}, {29'b0, res_idx}, {29'b0, eidx});
    if (v) chk({req, " addr"}, res_addr, eaddr);
    chk({req, " pf"}, {31'b0, res_prefetch}, {31'b0, epf});
  endtask

  task automatic t_reset;
    chk("R8 reset valid", {31'b0, res_valid}, 32'd0);
    rd_chk("R1 img1 mask", 1, 1, 32'hFFF0_0000);
    rd_chk("R1 img1 base", 1, 0, 32'h0);
    rd_chk("R1 img2 ctrl", 2, 3, 32'h0);
    rd_chk("R1 img3 xlat", 3, 2, 32'h0);
    rd_chk("R6 img0 mask", 0, 1, 32'hFFFF_F000);
    rd_chk("R7 img4 mask", 4, 1, 32'h0);
  endtask

  task automatic t_mask_norm;
    wr(1, 1, 32'hFF0F_0000); rd_chk("R2 hole", 1, 1, 32'hFF00_0000);
    wr(1, 1, 32'h7FFF_F000); rd_chk("R2 top zero", 1, 1, 32'h0);
    wr(1, 1, 32'hFFFF_FFFF); rd_chk("R2 full", 1, 1, 32'hFFFF_F000);
  endtask

  task automatic t_match;
    wr(1, 0, 32'h4000_0000); wr(1, 1, 32'hFFF0_0000);
    wr(2, 0, 32'h5000_0001); wr(2, 1, 32'hFF00_0000);
    rd_chk("R1 io bit", 2, 0, 32'h5000_0001);
    look("R3 mem hit", 32'h400A_BCDE, 1'b0, 1'b1, 6'b000010, 3'd1, 32'h400A_BCDE, 1'b0);
    look("R3 space miss", 32'h400A_BCDE, 1'b1, 1'b1, 6'b0, 3'd0, 32'h400A_BCDE, 1'b0);
    look("R3 io hit", 32'h5012_3456, 1'b1, 1'b1, 6'b000100, 3'd2, 32'h5012_3456, 1'b0);
    look("R3 io mem miss", 32'h5012_3456, 1'b0, 1'b1, 6'b0, 3'd0, 32'h5012_3456, 1'b0);
    look("R3 out of range", 32'h4100_0000, 1'b0, 1'b1, 6'b0, 3'd0, 32'h4100_0000, 1'b0);
    look("R3 default img3", 32'h0008_0000, 1'b0, 1'b1, 6'b001000, 3'd3, 32'h0008_0000, 1'b0);
    wr(3, 1, 32'h0);
    look("R3 zero mask", 32'h0008_0000, 1'b0, 1'b1, 6'b0, 3'd0, 32'h0008_0000, 1'b0);
  endtask

  task automatic t_prio;
    wr(3, 0, 32'h4000_0000); wr(3, 1, 32'hFFF0_0000);
    look("R4 low wins", 32'h4000_0010, 1'b0, 1'b1, 6'b000010, 3'd1, 32'h4000_0010, 1'b0);
    wr(0, 0, 32'h4000_0000);
    look("R4 img0 wins", 32'h4000_0010, 1'b0, 1'b1, 6'b000001, 3'd0, 32'h4000_0010, 1'b0);
    look("R4 next page", 32'h4000_1010, 1'b0, 1'b1, 6'b000010, 3'd1, 32'h4000_1010, 1'b0);
  endtask

  task automatic t_xlat;
    wr(1, 2, 32'h1234_5000); wr(1, 3, 32'h6);
    rd_chk("R1 ctrl read", 1, 3, 32'h6);
    look("R5 translate", 32'h400A_BCDE, 1'b0, 1'b1, 6'b000010, 3'd1, 32'h123A_BCDE, 1'b1);
    wr(1, 3, 32'h2);
    look("R5 disabled", 32'h400A_BCDE, 1'b0, 1'b1, 6'b000010, 3'd1, 32'h400A_BCDE, 1'b1);
    wr(1, 3, 32'h0);
    look("R9 pf off", 32'h400A_BCDE, 1'b0, 1'b1, 6'b000010, 3'd1, 32'h400A_BCDE, 1'b0);
  endtask

  task automatic t_cfg;
    wr(0, 1, 32'h0);         rd_chk("R6 mask locked", 0, 1, 32'hFFFF_F000);
    wr(0, 2, 32'hFFFF_F000); rd_chk("R6 xlat zero", 0, 2, 32'h0);
    wr(0, 3, 32'h6);         rd_chk("R6 ctrl zero", 0, 3, 32'h0);
    wr(0, 0, 32'h4000_0001); rd_chk("R6 mem only base", 0, 0, 32'h4000_0000);
    look("R6 io ignored", 32'h4000_0123, 1'b1, 1'b1, 6'b0, 3'd0, 32'h4000_0123, 1'b0);
    look("R6 no xlat", 32'h4000_0123, 1'b0, 1'b1, 6'b000001, 3'd0, 32'h4000_0123, 1'b0);
  endtask

  task automatic t_absent;
    wr(4, 0, 32'h7000_0000); wr(4, 1, 32'hFFF0_0000); wr(4, 3, 32'h6);
    rd_chk("R7 img4 base", 4, 0, 32'h0);
    rd_chk("R7 img4 ctrl", 4, 3, 32'h0);
    wr(5, 1, 32'hFFFF_F000); rd_chk("R7 img5 mask", 5, 1, 32'h0);
    wr(7, 0, 32'h7000_0000); rd_chk("R7 sel7", 7, 0, 32'h0);
    rd_chk("R7 sel6", 6, 1, 32'h0);
    look("R7 never hit", 32'h7000_0040, 1'b0, 1'b1, 6'b0, 3'd0, 32'h7000_0040, 1'b0);
  endtask

  task automatic t_idle;
    look("R8 idle", 32'h400A_BCDE, 1'b0, 1'b0, 6'b0, 3'd0, 32'h0, 1'b0);
    look("R8 resume", 32'h400A_BCDE, 1'b0, 1'b1, 6'b000010, 3'd1, 32'h400A_BCDE, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_norm();
    t_match();
    t_prio();
    t_xlat();
    t_cfg();
    t_absent();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule